// File: doc/BRIEF.md
# Byte-Queue Serial Transmitter

This block takes bytes written by a host into an internal byte queue and sends them out one bit at a time toward a modulator. The queue depth is chosen at run time from four sizes. Each pulse of a bit-rate strobe moves the output to the next bit, most significant bit first. A new byte is pulled from the queue as soon as the previous byte's last bit has had its full bit period.

Four event sources are produced:

- a burst-start event
- a queue-full level
- a transmission-complete flag
- a per-bit data-clock pulse

Each source is steered onto one of two interrupt lines by a routing word. A write that arrives while the queue is full is dropped, and a sticky overflow flag records it.

Top module: `txser_top`

## Requirements
- R1: After reset `serialOut`, `irq0`, `irq1` and `overflowFlag` are all 0.
- R2: The queue holds (`sizeSel`+1)*16 bytes. The full source (source index 1) is 1 exactly when that many bytes are stored.
- R3: While `txEnable` is 1, each `bitStrobe` cycle presents the next bit of the current byte on `serialOut`, most significant bit first. An idle block loads the head byte on a strobe and shows its bit 7 at once.
- R4: Queued bytes follow each other with no gap. The strobe after a byte's bit 0 shows bit 7 of the next byte.
- R5: The done source (index 2) becomes 1 on the strobe that ends the last bit's period while the queue is empty, and then `serialOut` returns to 0. It is 0 while the last bit is still presented. An accepted write or `txEnable` low clears it.
- R6: The start source (index 0) is 1 for one bit period, from the strobe that loads a byte into an idle shifter until the next strobe. A byte loaded back-to-back does not raise it.
- R7: The data-clock source (index 3) pulses for one clock cycle after each strobe that presents a bit. A strobe that presents no bit leaves it at 0.
- R8: A write while the queue is full is dropped and sets `overflowFlag`, which stays 1 until reset. The dropped byte is never transmitted.
- R9: Routing bit i of `irqRoute` set to 0 puts source i on `irq0`, and set to 1 puts it on `irq1`. Each line is the OR of its sources.
- R10: While `txEnable` is 0, strobes are ignored. `serialOut` and the bit position hold, and no data-clock pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txEnable | input | 1 | Allows serialization |
| sizeSel | input | 2 | Queue capacity select, (n+1)*16 bytes |
| wrValid | input | 1 | Host write strobe |
| wrData | input | 8 | Host write byte |
| bitStrobe | input | 1 | One-cycle bit-rate tick |
| irqRoute | input | 4 | Per-source line select: 0 start, 1 full, 2 done, 3 data clock |
| serialOut | output | 1 | Serial data toward the modulator |
| irq0 | output | 1 | Interrupt line 0 |
| irq1 | output | 1 | Interrupt line 1 |
| overflowFlag | output | 1 | Sticky dropped-write flag |

## Verification
The in-RTL assertions check the following on every cycle:

- the queue is never pushed when full and never popped when empty;
- done is only raised with an empty queue and an idle shifter;
- start only appears while a byte is in the shifter;
- overflow never falls;
- the bit position freezes while transmission is disabled.

Only the bench scenarios can show the rest: the exact bit order on the line, the back-to-back byte joins, the capacity for each size setting, the dropped byte missing from the output stream, and the interrupt routing.

// File: rtl/txser_pkg.sv
package txser_pkg;
  localparam int NUM_SRC = 4;
  localparam int SRC_START = 0;
  localparam int SRC_FULL = 1;
  localparam int SRC_DONE = 2;
  localparam int SRC_DCLK = 3;

  typedef struct packed {
    logic push;
    logic load;
    logic shift;
    logic drain;
  } txCmd_t;
endpackage

// File: rtl/txser_datapath.sv
module txser_datapath
  import txser_pkg::*;
#(
  parameter int BLOCK_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] sizeSel,
  input  logic [7:0] wrData,
  input  txCmd_t     cmd,
  output logic       fifoEmpty,
  output logic       fifoFull,
  output logic       serialBit
);
  localparam int MAX_BYTES = 4 * BLOCK_BYTES;
  localparam int PTR_W = $clog2(MAX_BYTES);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);

  logic [7:0]       mem [MAX_BYTES];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count, capacity;
  logic [7:0]       shReg;

  assign capacity  = CNT_W'((32'(sizeSel) + 1) * BLOCK_BYTES);
  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count >= capacity);
  assign serialBit = shReg[7];

  always_ff @(posedge clk) begin
    if (cmd.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == PTR_W'(MAX_BYTES - 1)) ? '0 : wrPtr + 1'b1;
      if (cmd.load) rdPtr <= (rdPtr == PTR_W'(MAX_BYTES - 1)) ? '0 : rdPtr + 1'b1;
      case ({cmd.push, cmd.load})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          shReg <= '0;
    else if (cmd.load)  shReg <= mem[rdPtr];
    else if (cmd.shift) shReg <= {shReg[6:0], 1'b0};
    else if (cmd.drain) shReg <= '0;
  end

  // R2: capacity limit respected by the controller
  a_r2_no_push_when_full: assert property (@(posedge clk) disable iff (!rstN)
    cmd.push |-> !fifoFull);
  a_r2_no_load_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    cmd.load |-> !fifoEmpty);
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/txser_ctrl.sv
module txser_ctrl
  import txser_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   txEnable,
  input  logic   wrValid,
  input  logic   bitStrobe,
  input  logic   fifoEmpty,
  input  logic   fifoFull,
  output txCmd_t cmd,
  output logic   startEvt,
  output logic   doneEvt,
  output logic   dclkEvt,
  output logic   overflowFlag
);
  logic       go;
  logic [3:0] bitCnt;

  assign go = bitStrobe & txEnable;

  always_comb begin
    cmd       = '0;
    cmd.push  = wrValid & ~fifoFull;
    cmd.shift = go & (bitCnt > 4'd1);
    cmd.load  = go & (bitCnt <= 4'd1) & ~fifoEmpty;
    cmd.drain = go & (bitCnt == 4'd1) & fifoEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bitCnt       <= '0;
      startEvt     <= 1'b0;
      doneEvt      <= 1'b0;
      dclkEvt      <= 1'b0;
      overflowFlag <= 1'b0;
    end else begin
      if (cmd.load)       bitCnt <= 4'd8;
      else if (cmd.shift) bitCnt <= bitCnt - 1'b1;
      else if (cmd.drain) bitCnt <= '0;

      if (!txEnable) startEvt <= 1'b0;
      else if (go)   startEvt <= cmd.load & (bitCnt == 4'd0);

      if (!txEnable || cmd.push) doneEvt <= 1'b0;
      else if (cmd.drain)        doneEvt <= 1'b1;

      dclkEvt <= cmd.shift | cmd.load;
      if (wrValid && fifoFull) overflowFlag <= 1'b1;
    end
  end

  // R5: done only with empty queue and idle shifter
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    doneEvt |-> (fifoEmpty && bitCnt == 4'd0));
  // R6: start only while a byte is in flight
  a_r6_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    startEvt |-> (bitCnt != 4'd0));
  // R8: overflow is sticky
  a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);
  // R10: bit position frozen while disabled
  a_r10_hold_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !txEnable |=> $stable(bitCnt));
  a_r3_count_range: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= 4'd8);
endmodule

// File: rtl/txser_top.sv
module txser_top
  import txser_pkg::*;
#(
  parameter int BLOCK_BYTES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txEnable,
  input  logic [1:0] sizeSel,
  input  logic       wrValid,
  input  logic [7:0] wrData,
  input  logic       bitStrobe,
  input  logic [3:0] irqRoute,
  output logic       serialOut,
  output logic       irq0,
  output logic       irq1,
  output logic       overflowFlag
);
  txCmd_t cmd;
  logic fifoEmpty, fifoFull, startEvt, doneEvt, dclkEvt;
  logic [NUM_SRC-1:0] srcVec, toIrq0, toIrq1;

  txser_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .wrValid(wrValid),
    .bitStrobe(bitStrobe), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .cmd(cmd), .startEvt(startEvt), .doneEvt(doneEvt), .dclkEvt(dclkEvt),
    .overflowFlag(overflowFlag)
  );

  txser_datapath #(.BLOCK_BYTES(BLOCK_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .sizeSel(sizeSel), .wrData(wrData), .cmd(cmd),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .serialBit(serialOut)
  );

  assign srcVec[SRC_START] = startEvt;
  assign srcVec[SRC_FULL]  = fifoFull;
  assign srcVec[SRC_DONE]  = doneEvt;
  assign srcVec[SRC_DCLK]  = dclkEvt;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_route
    assign toIrq0[i] = srcVec[i] & ~irqRoute[i];
    assign toIrq1[i] = srcVec[i] &  irqRoute[i];
  end

  assign irq0 = |toIrq0;
  assign irq1 = |toIrq1;

  // R9: a source never appears on both lines
  a_r9_exclusive_route: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(toIrq0 & toIrq1) && ((toIrq0 & toIrq1) == '0));
endmodule

// File: tb/txser_top_tb.sv
module txser_top_tb;
  logic clk = 0, rstN = 0, txEnable = 0, wrValid = 0, bitStrobe = 0;
  logic [1:0] sizeSel = 0;
  logic [7:0] wrData = 0;
  logic [3:0] irqRoute = 4'hF;
  logic serialOut, irq0, irq1, overflowFlag;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  txser_top u_dut (
    .clk(clk), .rstN(rstN), .txEnable(txEnable), .sizeSel(sizeSel),
    .wrValid(wrValid), .wrData(wrData), .bitStrobe(bitStrobe),
    .irqRoute(irqRoute), .serialOut(serialOut), .irq0(irq0), .irq1(irq1),
    .overflowFlag(overflowFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; txEnable = 0; wrValid = 0; bitStrobe = 0; irqRoute = 4'hF;
    repeat (2) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk); wrValid = 1; wrData = b;
    @(negedge clk); wrValid = 0;
  endtask

  task automatic strobe();
    @(negedge clk); bitStrobe = 1;
    @(negedge clk); bitStrobe = 0;
  endtask

  // routes only source src to irq0 and reads it
  task automatic peek(input int src, output int v);
    irqRoute = 4'hF & ~(4'b1 << src);
    #0.5;
    v = int'(irq0);
    irqRoute = 4'hF;
  endtask

  task automatic sendByte(input logic [7:0] b, input string req);
    for (int i = 7; i >= 0; i--) begin
      strobe();
      check(req, int'(serialOut), int'(b[i]));
    end
  endtask

  task automatic testReset();
    doReset();
    check("R1 serialOut", int'(serialOut), 0);
    check("R1 irq0", int'(irq0), 0);
    check("R1 irq1", int'(irq1), 0);
    check("R1 overflow", int'(overflowFlag), 0);
  endtask

  task automatic testSerial();
    int v;
    doReset();
    txEnable = 1;
    pushByte(8'hA5);
    pushByte(8'h3C);
    strobe();
    check("R3 first bit", int'(serialOut), 1);
    peek(0, v); check("R6 start set", v, 1);
    peek(3, v); check("R7 dclk pulse", v, 1);
    @(negedge clk);
    peek(3, v); check("R7 dclk one cycle", v, 0);
    strobe();
    check("R3 bit6", int'(serialOut), 0);
    peek(0, v); check("R6 start cleared", v, 0);
    for (int i = 5; i >= 0; i--) begin
      strobe();
      check("R3 bits", int'(serialOut), int'(8'hA5 >> i) & 1);
    end
    strobe();
    check("R4 next msb", int'(serialOut), 0);
    peek(0, v); check("R6 no start back-to-back", v, 0);
    for (int i = 6; i >= 0; i--) begin
      strobe();
      check("R4 bits", int'(serialOut), int'(8'h3C >> i) & 1);
    end
    peek(2, v); check("R5 not done on last bit", v, 0);
    strobe();
    peek(2, v); check("R5 done set", v, 1);
    check("R5 line idle", int'(serialOut), 0);
    strobe();
    peek(3, v); check("R7 no dclk idle", v, 0);
    peek(2, v); check("R5 done held", v, 1);
    pushByte(8'h80);
    peek(2, v); check("R5 done cleared by write", v, 0);
    strobe();
    check("R3 load 80", int'(serialOut), 1);
    txEnable = 0;
    strobe();
    check("R10 hold out", int'(serialOut), 1);
    peek(3, v); check("R10 no dclk", v, 0);
    strobe();
    check("R10 hold out2", int'(serialOut), 1);
    txEnable = 1;
    strobe();
    check("R10 resumes bit6", int'(serialOut), 0);
    repeat (7) strobe();
    peek(2, v); check("R5 done again", v, 1);
    txEnable = 0;
    @(negedge clk);
    peek(2, v); check("R5 cleared by disable", v, 0);
  endtask

  task automatic testCapacity();
    int v;
    for (int s = 0; s < 4; s++) begin
      doReset();
      sizeSel = 2'(s);
      for (int k = 0; k < (s + 1) * 16 - 1; k++) pushByte(8'(k));
      peek(1, v); check("R2 not full at cap-1", v, 0);
      pushByte(8'h11);
      peek(1, v); check("R2 full at cap", v, 1);
      check("R2 no overflow at cap", int'(overflowFlag), 0);
    end
    sizeSel = 0;
  endtask

  task automatic testOverflow();
    int v;
    doReset();
    sizeSel = 0;
    for (int k = 0; k < 16; k++) pushByte(8'(k * 13 + 7));
    pushByte(8'hFF);
    check("R8 overflow set", int'(overflowFlag), 1);
    txEnable = 1;
    for (int k = 0; k < 16; k++) sendByte(8'(k * 13 + 7), "R8 stream");
    strobe();
    peek(2, v); check("R8 dropped byte not sent", v, 1);
    check("R8 line idle", int'(serialOut), 0);
    check("R8 overflow sticky", int'(overflowFlag), 1);
  endtask

  task automatic testRouting();
    doReset();
    txEnable = 1;
    pushByte(8'h01);
    repeat (9) strobe();
    irqRoute = 4'b0100; #0.5;
    check("R9 done on irq1", int'(irq1), 1);
    check("R9 irq0 quiet", int'(irq0), 0);
    irqRoute = 4'b0000; #0.5;
    check("R9 done on irq0", int'(irq0), 1);
    check("R9 irq1 quiet", int'(irq1), 0);
    irqRoute = 4'hF;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    testReset();
    testSerial();
    testCapacity();
    testOverflow();
    testRouting();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule